// File: doc/BRIEF.md
# Colour-Button Sequence Lock

The block watches three colour buttons (red, green, blue) and a shared "a button is down" level. Once it has been armed by a start pulse, it checks that the next four presses follow the fixed order red, blue, green, red. When the fourth press is correct, the unlock flag rises for exactly one clock cycle. A press of the wrong colour aborts the attempt and the lock returns to idle. It must then be armed again.

The machine reacts to press events, not to levels. A press is the cycle in which the shared pressed level first reads high after reading low, and the colour lines are sampled in that same cycle. A button held for many cycles therefore counts once. Between presses the machine waits for as long as needed. The block has no streaming data path, so every pin is a plain control or status level; there is no handshake and no back-pressure. Debouncing is left to the logic that drives the pins.

Top module: `colour_code_lock`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, the lock is idle and unlock_o is 0.
- R2: In idle, the lock arms when start_i=1 at a clock edge; otherwise it stays idle. In idle, presses have no effect, so a code entered without arming never unlocks.
- R3: While armed or part-way through the code, the lock keeps its progress at every edge that carries no new press, however long the gap is. start_i has no effect in these states.
- R4: Once armed, presses in the order red, blue, green, red make unlock_o go to 1 in the cycle after the edge that samples the last red press.
- R5: A press of a single wrong colour at any step returns the lock to idle. The lock must then be armed again before it can unlock.
- R6: A press with zero colour lines high, or with two or more high, counts as wrong and returns the lock to idle.
- R7: unlock_o stays 1 for exactly one cycle. The lock is then idle and needs a new arming.
- R8: Only a 0-to-1 change of any_press_i is a press. A level held high for several cycles counts as one press. A press that is already held when the lock arms does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms the lock from idle |
| any_press_i | input | 1 | High while any colour button is held |
| red_i | input | 1 | Red button level |
| green_i | input | 1 | Green button level |
| blue_i | input | 1 | Blue button level |
| unlock_o | output | 1 | One-cycle pulse when the code is complete |

## Verification
On every cycle the assertions check four things: how the idle state moves, that progress holds when there is no press, that mixed or empty colour presses lead to idle, and that the unlock pulse lasts one cycle and follows a fresh red press edge. Some behaviours can only be seen over a whole scenario, which the bench's reference model covers. These are that a code entered without arming never unlocks, that a long-held button counts once, that a single wrong colour cancels the attempt, and that start pulses in the middle of a code are ignored.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int unsigned N_COLOURS = 3;
  localparam int unsigned STATE_W   = 3;

  // index of each colour inside the packed colour-line vector
  localparam int unsigned IDX_RED   = 0;
  localparam int unsigned IDX_GREEN = 1;
  localparam int unsigned IDX_BLUE  = 2;

  typedef enum logic [1:0] {
    CL_RED   = 2'd0,
    CL_GREEN = 2'd1,
    CL_BLUE  = 2'd2,
    CL_BAD   = 2'd3
  } col_e;

  typedef enum logic [STATE_W-1:0] {
    LK_IDLE   = 3'd0,
    LK_ARMED  = 3'd1,
    LK_GOT_R1 = 3'd2,
    LK_GOT_B  = 3'd3,
    LK_GOT_G  = 3'd4,
    LK_OPEN   = 3'd5
  } lock_state_e;

  // colour that moves the lock on from a given step
  function automatic col_e want_colour(lock_state_e s);
    case (s)
      LK_ARMED:  want_colour = CL_RED;
      LK_GOT_R1: want_colour = CL_BLUE;
      LK_GOT_B:  want_colour = CL_GREEN;
      LK_GOT_G:  want_colour = CL_RED;
      default:   want_colour = CL_BAD;
    endcase
  endfunction

  // step reached after a correct press
  function automatic lock_state_e step_after(lock_state_e s);
    case (s)
      LK_ARMED:  step_after = LK_GOT_R1;
      LK_GOT_R1: step_after = LK_GOT_B;
      LK_GOT_B:  step_after = LK_GOT_G;
      LK_GOT_G:  step_after = LK_OPEN;
      default:   step_after = LK_IDLE;
    endcase
  endfunction

  function automatic logic in_code(lock_state_e s);
    in_code = (s == LK_ARMED) || (s == LK_GOT_R1) ||
              (s == LK_GOT_B) || (s == LK_GOT_G);
  endfunction

endpackage

// File: rtl/lock_press_edge.sv
module lock_press_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic press_o
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign press_o = level_i & ~level_q;

endmodule

// File: rtl/lock_colour_decode.sv
module lock_colour_decode
  import lock_pkg::*;
#(
  parameter int unsigned NC = N_COLOURS
) (
  input  logic [NC-1:0] lines_i,
  output col_e          colour_o
);

  localparam int unsigned CNT_W = $clog2(NC + 1);

  logic [CNT_W-1:0] high_cnt;

  always_comb begin
    high_cnt = '0;
    for (int i = 0; i < NC; i++) high_cnt = high_cnt + CNT_W'(lines_i[i]);
  end

  always_comb begin
    colour_o = CL_BAD;
    if (high_cnt == CNT_W'(1)) begin
      if (lines_i[IDX_RED])        colour_o = CL_RED;
      else if (lines_i[IDX_GREEN]) colour_o = CL_GREEN;
      else if (lines_i[IDX_BLUE])  colour_o = CL_BLUE;
    end
  end

endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        press_i,
  input  col_e        colour_i,
  output lock_state_e state_o
);

  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LK_IDLE: if (start_i) state_d = LK_ARMED;
      LK_OPEN: state_d = LK_IDLE;
      LK_ARMED, LK_GOT_R1, LK_GOT_B, LK_GOT_G: begin
        if (press_i) begin
          if (colour_i == want_colour(state_q)) state_d = step_after(state_q);
          else                                  state_d = LK_IDLE;
        end
      end
      default: state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/colour_code_lock.sv
module colour_code_lock
  import lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic any_press_i,
  input  logic red_i,
  input  logic green_i,
  input  logic blue_i,
  output logic unlock_o
);

  logic [N_COLOURS-1:0] lines;
  logic                 press_evt;
  col_e                 colour;
  lock_state_e          state;

  always_comb begin
    lines            = '0;
    lines[IDX_RED]   = red_i;
    lines[IDX_GREEN] = green_i;
    lines[IDX_BLUE]  = blue_i;
  end

  lock_press_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (any_press_i),
    .press_o (press_evt)
  );

  lock_colour_decode #(.NC(N_COLOURS)) u_decode (
    .lines_i  (lines),
    .colour_o (colour)
  );

  lock_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .press_i  (press_evt),
    .colour_i (colour),
    .state_o  (state)
  );

  assign unlock_o = (state == LK_OPEN);

endmodule

// File: rtl/colour_code_lock_chk.sv
module colour_code_lock_chk
  import lock_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        any_press_i,
  input logic        red_i,
  input logic        green_i,
  input logic        blue_i,
  input logic        unlock_o,
  input logic        press_evt,
  input lock_state_e state
);

  // R2: idle leaves only on start
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_IDLE && !start_i) |=> (state == LK_IDLE));

  p_idle_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_IDLE && start_i) |=> (state == LK_ARMED));

  // R3: no press, no change in the code steps
  p_hold_no_press_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_code(state) && !press_evt) |=> $stable(state));

  // R6: empty or mixed colour press aborts
  p_bad_mix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_code(state) && press_evt && ($countones({red_i, green_i, blue_i}) != 1))
      |=> (state == LK_IDLE));

  // R5: wrong single colour at the blue step aborts
  p_wrong_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_GOT_R1 && press_evt && !blue_i &&
     ($countones({red_i, green_i, blue_i}) == 1)) |=> (state == LK_IDLE));

  // R7: unlock is a single-cycle pulse
  p_unlock_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_o |=> !unlock_o);

  // R4: unlock follows a clean red press
  p_unlock_after_red_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_o) |-> $past(any_press_i && red_i && !green_i && !blue_i));

  // R8: the final press was a fresh rising edge
  p_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_o) |-> !$past(any_press_i, 2));

endmodule

bind colour_code_lock colour_code_lock_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .any_press_i (any_press_i),
  .red_i       (red_i),
  .green_i     (green_i),
  .blue_i      (blue_i),
  .unlock_o    (unlock_o),
  .press_evt   (press_evt),
  .state       (state)
);

// File: tb/colour_code_lock_tb_top.sv
`timescale 1ns/1ps
module colour_code_lock_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, any_press_i = 1'b0;
  logic red_i = 1'b0, green_i = 1'b0, blue_i = 1'b0;
  logic unlock_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int open_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  colour_code_lock dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .any_press_i(any_press_i),
    .red_i(red_i), .green_i(green_i), .blue_i(blue_i), .unlock_o(unlock_o)
  );

  // behavioural reference: 0 idle, 1 armed, 2..4 codes matched, 5 open
  int  ref_phase = 0;
  bit  ref_prev  = 1'b0;

  function automatic int want(int ph);
    case (ph)
      1: want = 0;  // red
      2: want = 2;  // blue
      3: want = 1;  // green
      4: want = 0;  // red
      default: want = -1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_phase = 0;
      ref_prev  = 1'b0;
    end else begin
      int n_high;
      int col;
      bit evt;
      evt    = any_press_i && !ref_prev;
      n_high = int'(red_i) + int'(green_i) + int'(blue_i);
      col    = red_i ? 0 : (green_i ? 1 : 2);
      if (ref_phase == 0) begin
        if (start_i) ref_phase = 1;
      end else if (ref_phase == 5) begin
        ref_phase = 0;
      end else if (evt) begin
        if (n_high == 1 && col == want(ref_phase)) ref_phase = ref_phase + 1;
        else ref_phase = 0;
      end
      ref_prev = any_press_i;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (unlock_o !== (ref_phase == 5)) begin
        errors++;
        $display("FAIL R4 model compare cycle %0d: unlock=%0b expected=%0b",
                 cyc, unlock_o, (ref_phase == 5));
      end
      if (unlock_o) open_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_cnt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // colour code: 0 red, 1 green, 2 blue; mask form for mixed presses
  task automatic press_mask(input logic [2:0] m, input int hold);
    @(negedge clk);
    red_i = m[0]; green_i = m[1]; blue_i = m[2]; any_press_i = 1'b1;
    for (int i = 1; i < hold; i++) @(negedge clk);
    @(negedge clk);
    red_i = 1'b0; green_i = 1'b0; blue_i = 1'b0; any_press_i = 1'b0;
  endtask

  task automatic press(input int c, input int hold);
    press_mask(3'b001 << c, hold);
  endtask

  task automatic code_rest();   // blue, green, red
    press(2, 1); idle(2);
    press(1, 1); idle(2);
    press(0, 1); idle(3);
  endtask

  initial begin
    idle(1);
    check("R1 unlock low in reset", unlock_o, 1'b0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 unlock low after reset", unlock_o, 1'b0);

    // R4 + R7: correct code with pulse timing
    open_cnt = 0;
    arm();
    press(0, 1); idle(1);
    press(2, 1); idle(1);
    press(1, 1); idle(1);
    @(negedge clk); red_i = 1'b1; any_press_i = 1'b1;
    @(negedge clk); red_i = 1'b0; any_press_i = 1'b0;
    check("R4 unlock after last red", unlock_o, 1'b1);
    @(negedge clk);
    check("R7 unlock drops after one cycle", unlock_o, 1'b0);
    idle(2);
    check_cnt("R7 single pulse count", open_cnt, 1);

    // R7: after opening, a new code without arming fails
    open_cnt = 0;
    press(0, 1); idle(1); code_rest();
    check_cnt("R7 needs new arming", open_cnt, 0);

    // R2: code with no arming at all, after reset idle
    open_cnt = 0;
    press(0, 1); idle(2); code_rest();
    check_cnt("R2 unarmed code ignored", open_cnt, 0);

    // R3: long gaps and stray start pulses keep progress
    open_cnt = 0;
    arm(); idle(40);
    press(0, 1); idle(30); arm(); idle(10);
    press(2, 1); idle(50);
    press(1, 1); arm(); idle(25);
    press(0, 1); idle(3);
    check_cnt("R3 long waits and start ignored", open_cnt, 1);

    // R8: long-held buttons count once
    open_cnt = 0;
    arm();
    press(0, 12); idle(1);
    press(2, 9); idle(1);
    press(1, 7); idle(1);
    press(0, 5); idle(3);
    check_cnt("R8 held level counts once", open_cnt, 1);

    // R8: press already held when arming is not a press
    open_cnt = 0;
    @(negedge clk); red_i = 1'b1; any_press_i = 1'b1;
    arm(); idle(3);
    @(negedge clk); red_i = 1'b0; any_press_i = 1'b0;
    idle(1);
    code_rest();
    check_cnt("R8 held-through-arm not a press", open_cnt, 0);

    // R5: wrong single colour at step two, then rest of code
    open_cnt = 0;
    arm(); press(0, 1); idle(1);
    press(1, 1); idle(1);
    code_rest();
    check_cnt("R5 wrong colour aborts", open_cnt, 0);

    // R5: wrong first colour
    open_cnt = 0;
    arm(); press(2, 1); idle(1);
    press(0, 1); idle(1); code_rest();
    check_cnt("R5 wrong first colour aborts", open_cnt, 0);

    // R5: recovery after abort with fresh arming
    open_cnt = 0;
    arm(); press(0, 1); idle(1); code_rest();
    check_cnt("R5 re-arm after abort opens", open_cnt, 1);

    // R6: two colours at once
    open_cnt = 0;
    arm(); press(0, 1); idle(1);
    press_mask(3'b110, 1); idle(1);
    press(1, 1); idle(1); press(0, 1); idle(3);
    check_cnt("R6 mixed colours abort", open_cnt, 0);

    // R6: press with no colour line
    open_cnt = 0;
    arm(); press(0, 1); idle(1);
    press_mask(3'b000, 1); idle(1);
    code_rest();
    check_cnt("R6 empty press aborts", open_cnt, 0);

    // R6: red plus blue at the final step
    open_cnt = 0;
    arm(); press(0, 1); idle(1);
    press(2, 1); idle(1); press(1, 1); idle(1);
    press_mask(3'b101, 1); idle(3);
    check_cnt("R6 mixed final press aborts", open_cnt, 0);

    // R1: asynchronous reset mid-code discards progress
    open_cnt = 0;
    arm(); press(0, 1); idle(1); press(2, 1);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1 unlock low during mid-code reset", unlock_o, 1'b0);
    #1 rst_n = 1'b1;
    idle(1);
    press(1, 1); idle(1); press(0, 1); idle(3);
    check_cnt("R1 reset clears progress", open_cnt, 0);

    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule